// File: doc/BRIEF.md
# Contactless Type B Request Frame Receiver

This block recovers request frames from a reader on a proximity card link. Its input is the demodulated envelope as a clean logic-level stream, oversampled at a fixed number of clock samples per elementary time unit (ETU, one bit time at 106 kbit/s). The block looks for the long low run and the high guard time that open a frame. It then times every 10-bit character from that character's own start-bit falling edge and reads each bit at mid-ETU. Each received byte is handed out as a one-cycle strobe.

A character slot that stays low through its stop bit is taken as the closing low run. When the line rises again, the block checks the 16-bit CRC residue over all received bytes and the byte count. It then raises either a frame-valid or a frame-error pulse. Any framing fault aborts the frame with a frame-error pulse, and the block goes back to looking for a new opening pattern. Nothing is ever sent back toward the reader. The command decoder downstream discards the bytes of any frame that ends in an error.

Top module: `typeb_req_rx`

## Requirements
- R1: While reset is asserted, byte_valid, frame_valid and frame_error are 0. After reset the block is looking for a frame opening.
- R2: A frame opens only on a low run of 152 to 168 samples, that is 10 ETU plus or minus half an ETU at 16 samples per ETU. Low runs outside that window are ignored with no output.
- R3: The high guard after the opening low run must last 32 to 48 samples (2 to 3 ETU). If the line falls earlier, frame_error pulses for that falling sample. If the line is still high on the 49th sample, frame_error pulses for that sample.
- R4: A character is a start bit of 0, then eight data bits least significant first, then a stop bit of 1. Bit n is read at sample 16n+8 counted from the start-bit falling sample (sample 0). With a stop bit of 1, byte_valid pulses for one cycle with byte_data set, decided on the stop-bit sample (sample 152). Every output responds to the rx_in sample taken at clock edge k just after edge k+1.
- R5: Each character is timed from its own start-bit falling edge, whatever the spacing. Up to 96 extra high samples (6 ETU) after the stop bit are accepted. A high run lasting through the sample 104 samples past the stop-bit sample gives frame_error for that sample.
- R6: If the start bit reads 1 at its mid sample (sample 8), frame_error pulses for that sample.
- R7: If the stop bit reads 0 while the data bits are not all 0, frame_error pulses for the stop-bit sample.
- R8: If a character slot reads all 0 including the stop bit, it is the closing low run. The frame ends at the first high sample, provided that comes before the 169th low sample. Otherwise frame_error pulses for the 169th low sample.
- R9: The CRC is a reflected 0x8408 CRC, preset to FFFFh and complemented at the end, sent low byte first with each byte least significant bit first. At the end of the frame, frame_valid pulses if at least 3 bytes were received and the residue over all of them matches. Otherwise frame_error pulses.
- R10: After any frame_error, or after a low run is rejected, the next correctly formed frame is received normally.
- R11: byte_valid, frame_valid and frame_error are one-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 samples per ETU by default |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Demodulated envelope, 1 = unmodulated |
| byte_valid | output | 1 | One-cycle strobe for each received byte |
| byte_data | output | 8 | Received byte, valid while byte_valid is 1 |
| frame_valid | output | 1 | One-cycle pulse: the frame closed with good CRC and length |
| frame_error | output | 1 | One-cycle pulse: the frame was aborted or failed its check |

## Verification
The bench sends well-formed frames under several timing patterns. These vary the opening low run across its whole window, the guard time at 2, 2.5 and 3 ETU, and the gap between characters at zero, a non-integral 37 samples and the 6 ETU maximum. Together these separate correct per-character resynchronisation from timing taken once per frame. Corrupted frames then fault each stage in turn: a too-short or too-long guard, a glitch instead of a start bit, a low stop bit, an overlong gap, an overlong closing run, a bad CRC and a frame that is too short. Each one shows that the error surfaces on the exact sample the requirements name. A clean frame sent after all these faults shows that the block recovers. Opening low runs just outside the window must produce no output at all.

// File: rtl/typeb_req_rx.sv
module typeb_req_rx #(
  parameter int ETU       = 16,
  parameter int EGT_ETU   = 6,
  parameter int MIN_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_valid,
  output logic       frame_error
);
  localparam int HALF     = ETU / 2;
  localparam int LO_MIN   = 10 * ETU - HALF;
  localparam int LO_MAX   = 10 * ETU + HALF;
  localparam int HI_MIN   = 2 * ETU;
  localparam int HI_MAX   = 3 * ETU;
  localparam int STOP_AT  = 9 * ETU + HALF;
  localparam int GAP_LIM  = HALF + EGT_ETU * ETU;
  localparam int CW       = $clog2(LO_MAX + 2);
  localparam int PW       = $clog2(ETU);
  localparam int NW       = $clog2(MIN_BYTES + 1);
  localparam logic [15:0] RESIDUE = 16'hF0B8;

  typedef enum logic [2:0] {S_HUNT, S_SOFL, S_SOFH, S_BIT, S_GAP, S_EOFL} st_t;

  st_t             st;
  logic            rx_q, rx_d;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   ph;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic [15:0]     crc;
  logic [NW-1:0]   nb;

  wire mid    = (ph == PW'(HALF));
  wire crc_ok = (crc == RESIDUE) && (nb == NW'(MIN_BYTES));

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_HUNT;
      rx_q        <= 1'b1;
      rx_d        <= 1'b1;
      cnt         <= '0;
      ph          <= '0;
      bitn        <= '0;
      sh          <= '0;
      crc         <= '1;
      nb          <= '0;
      byte_valid  <= 1'b0;
      byte_data   <= '0;
      frame_valid <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      rx_q        <= rx_in;
      rx_d        <= rx_q;
      byte_valid  <= 1'b0;
      frame_valid <= 1'b0;
      frame_error <= 1'b0;
      case (st)
        S_HUNT: begin
          if (rx_d && !rx_q) begin
            st  <= S_SOFL;
            cnt <= CW'(1);
          end
        end
        S_SOFL: begin
          if (!rx_q) begin
            if (cnt == CW'(LO_MAX)) st <= S_HUNT;
            else                    cnt <= cnt + 1'b1;
          end else if (cnt >= CW'(LO_MIN)) begin
            st  <= S_SOFH;
            cnt <= CW'(1);
          end else begin
            st <= S_HUNT;
          end
        end
        S_SOFH: begin
          if (rx_q) begin
            if (cnt == CW'(HI_MAX)) begin
              st          <= S_HUNT;
              frame_error <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt >= CW'(HI_MIN)) begin
            st   <= S_BIT;
            ph   <= PW'(1);
            bitn <= '0;
            crc  <= '1;
            nb   <= '0;
          end else begin
            st          <= S_HUNT;
            frame_error <= 1'b1;
          end
        end
        S_BIT: begin
          if (ph == PW'(ETU - 1)) begin
            ph   <= '0;
            bitn <= bitn + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
          if (mid) begin
            if (bitn == 4'd0) begin
              if (rx_q) begin
                st          <= S_HUNT;
                frame_error <= 1'b1;
              end
            end else if (bitn <= 4'd8) begin
              sh <= {rx_q, sh[7:1]};
            end else if (rx_q) begin
              byte_valid <= 1'b1;
              byte_data  <= sh;
              crc        <= crc_step(crc, sh);
              if (nb != NW'(MIN_BYTES)) nb <= nb + 1'b1;
              st         <= S_GAP;
              cnt        <= '0;
            end else if (sh == 8'h00) begin
              st  <= S_EOFL;
              cnt <= CW'(STOP_AT + 1);
            end else begin
              st          <= S_HUNT;
              frame_error <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (!rx_q) begin
            st   <= S_BIT;
            ph   <= PW'(1);
            bitn <= '0;
          end else if (cnt == CW'(GAP_LIM - 1)) begin
            st          <= S_HUNT;
            frame_error <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_EOFL: begin
          if (!rx_q) begin
            if (cnt == CW'(LO_MAX)) begin
              st          <= S_HUNT;
              frame_error <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            st          <= S_HUNT;
            frame_valid <= crc_ok;
            frame_error <= !crc_ok;
          end
        end
        default: st <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/typeb_req_rx_chk.sv
module typeb_req_rx_chk #(
  parameter int ETU       = 16,
  parameter int MIN_BYTES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic rx_in,
  input logic byte_valid,
  input logic frame_valid,
  input logic frame_error
);
  localparam int CHAR_SAMPLES = 10 * ETU;

  int since_b;
  int nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_b <= CHAR_SAMPLES;
      nbytes  <= 0;
    end else begin
      if (byte_valid)                    since_b <= 1;
      else if (since_b < CHAR_SAMPLES)   since_b <= since_b + 1;
      if (frame_valid || frame_error)    nbytes <= 0;
      else if (byte_valid && nbytes < MIN_BYTES) nbytes <= nbytes + 1;
    end
  end

  // R11
  one_pulse_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_valid, frame_valid, frame_error}));

  // R11
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R9
  min_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> nbytes >= MIN_BYTES);

  // R4
  byte_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> since_b >= CHAR_SAMPLES);

  // R8
  close_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ($past(rx_in, 2) && !$past(rx_in, 3)));
endmodule

bind typeb_req_rx typeb_req_rx_chk #(.ETU(ETU), .MIN_BYTES(MIN_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_in       (rx_in),
  .byte_valid  (byte_valid),
  .frame_valid (frame_valid),
  .frame_error (frame_error)
);

// File: tb/typeb_req_rx_bench.sv
module typeb_req_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ETU        = 16;
  localparam int STOP_OFS   = 9 * ETU + ETU / 2;

  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       byte_valid, frame_valid, frame_error;
  logic [7:0] byte_data;

  typeb_req_rx u_typeb_req_rx (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_valid(frame_valid), .frame_error(frame_error)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit    wv[$];
  int    s_kind[int];
  logic [7:0] s_byte[int];
  string s_tag[int];
  int    c_kind[int];
  logic [7:0] c_byte[int];
  string c_tag[int];

  always @(posedge clk) begin
    logic ebv, efv, efe;
    logic [7:0] eb;
    string t;
    #2;
    if (rst_n) begin
      ebv = c_kind.exists(cyc) && c_kind[cyc] == 1;
      efv = c_kind.exists(cyc) && c_kind[cyc] == 2;
      efe = c_kind.exists(cyc) && c_kind[cyc] == 3;
      eb  = c_byte.exists(cyc) ? c_byte[cyc] : 8'h00;
      t   = c_tag.exists(cyc) ? c_tag[cyc] : "R11";
      n_vec++;
      if (byte_valid !== ebv || frame_valid !== efv || frame_error !== efe ||
          (ebv && byte_data !== eb)) begin
        n_bad++;
        $display("FAIL %s cycle %0d: bv/fv/fe/data = %b%b%b/%h expected %b%b%b/%h",
                 t, cyc, byte_valid, frame_valid, frame_error, byte_data, ebv, efv, efe, eb);
      end
    end
  end

  function automatic logic [15:0] crc_of(bq_t q);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < q.size(); k++)
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ q[k][i];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  function automatic bq_t with_crc(bq_t p, bit bad);
    bq_t r;
    logic [15:0] c;
    r = p;
    c = crc_of(p);
    if (bad) c = c ^ 16'h0100;
    r.push_back(c[7:0]);
    r.push_back(c[15:8]);
    return r;
  endfunction

  task automatic lvl(input bit v, input int n);
    for (int i = 0; i < n; i++) wv.push_back(v);
  endtask

  task automatic expect_at(input int s, input int kind, input logic [7:0] b, input string t);
    s_kind[s] = kind;
    s_byte[s] = b;
    s_tag[s]  = t;
  endtask

  task automatic put_char(input logic [7:0] b, input bit stopb, input int gap);
    lvl(1'b0, ETU);
    for (int i = 0; i < 8; i++) lvl(b[i], ETU);
    lvl(stopb, ETU);
    lvl(1'b1, gap);
  endtask

  task automatic char_ok(input logic [7:0] b, input int gap, input string t);
    expect_at(wv.size() + STOP_OFS, 1, b, t);
    put_char(b, 1'b1, gap);
  endtask

  task automatic frame(input bq_t pay, input int lo, input int hi, input int gap,
                       input int eofl, input bit bad, input string t);
    bq_t full;
    int  f;
    full = with_crc(pay, bad);
    lvl(1'b1, 20);
    lvl(1'b0, lo);
    lvl(1'b1, hi);
    for (int k = 0; k < full.size(); k++)
      char_ok(full[k], (k == full.size() - 1) ? 0 : gap, t);
    f = wv.size();
    lvl(1'b0, eofl);
    expect_at(f + eofl, (full.size() >= 3 && !bad) ? 2 : 3, 8'h00, "R9");
    lvl(1'b1, 40);
  endtask

  task automatic run_wave();
    for (int i = 0; i < wv.size(); i++) begin
      @(negedge clk);
      rx_in = wv[i];
      if (s_kind.exists(i)) begin
        c_kind[cyc + 2] = s_kind[i];
        c_byte[cyc + 2] = s_byte[i];
        c_tag[cyc + 2]  = s_tag[i];
      end
    end
    wv.delete();
    s_kind.delete();
    s_byte.delete();
    s_tag.delete();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: run still busy at cycle %0d, expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    int r, f;
    repeat (3) @(posedge clk);
    #2;
    n_vec++;
    if ({byte_valid, frame_valid, frame_error} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 in reset: bv/fv/fe = %b%b%b expected 000", byte_valid, frame_valid, frame_error);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R4 R9: nominal frame
    frame('{8'h06, 8'h00}, 160, 40, 0, 160, 1'b0, "R4");
    run_wave();

    // R2 R3 R5: low run and guard at lower bounds, non-integral gap
    frame('{8'h08, 8'h05}, 152, 32, 37, 168, 1'b0, "R5");
    run_wave();

    // R2 R3 R5 R8: upper bounds, 6 ETU gap, shortest closing run
    frame('{8'h0B, 8'hFF, 8'h00, 8'hA5, 8'h3C}, 168, 48, 96, 153, 1'b0, "R5");
    run_wave();

    // R9: corrupted CRC
    frame('{8'h0E, 8'h42}, 160, 40, 16, 160, 1'b1, "R9");
    run_wave();

    // R9: only the CRC bytes, too short
    frame('{}, 160, 40, 0, 160, 1'b0, "R9");
    run_wave();

    // R2: low runs just outside the window give nothing
    lvl(1'b1, 20); lvl(1'b0, 150); lvl(1'b1, 100);
    lvl(1'b0, 170); lvl(1'b1, 100);
    run_wave();

    // R3: guard too short
    lvl(1'b1, 20); lvl(1'b0, 160);
    r = wv.size();
    lvl(1'b1, 24);
    expect_at(r + 24, 3, 8'h00, "R3");
    lvl(1'b0, 16); lvl(1'b1, 200);
    run_wave();

    // R3: guard too long
    lvl(1'b1, 20); lvl(1'b0, 160);
    r = wv.size();
    lvl(1'b1, 56);
    expect_at(r + 48, 3, 8'h00, "R3");
    lvl(1'b1, 100);
    run_wave();

    // R6: glitch instead of a start bit
    lvl(1'b1, 20); lvl(1'b0, 160); lvl(1'b1, 40);
    f = wv.size();
    lvl(1'b0, 4);
    expect_at(f + 8, 3, 8'h00, "R6");
    lvl(1'b1, 100);
    run_wave();

    // R7: low stop bit with nonzero data
    lvl(1'b1, 20); lvl(1'b0, 160); lvl(1'b1, 40);
    f = wv.size();
    put_char(8'h5A, 1'b0, 0);
    expect_at(f + STOP_OFS, 3, 8'h00, "R7");
    lvl(1'b1, 100);
    run_wave();

    // R5: gap one sample past the limit
    lvl(1'b1, 20); lvl(1'b0, 160); lvl(1'b1, 40);
    f = wv.size();
    char_ok(8'h11, 97, "R5");
    expect_at(f + 256, 3, 8'h00, "R5");
    lvl(1'b1, 50);
    run_wave();

    // R8: closing low run too long
    begin
      bq_t full;
      full = with_crc('{8'h06, 8'h00}, 1'b0);
      lvl(1'b1, 20); lvl(1'b0, 160); lvl(1'b1, 40);
      for (int k = 0; k < full.size(); k++) char_ok(full[k], 0, "R8");
      f = wv.size();
      lvl(1'b0, 180);
      expect_at(f + 168, 3, 8'h00, "R8");
      lvl(1'b1, 50);
      run_wave();
    end

    // R10: recovery after the faults above
    frame('{8'h0B, 8'h07}, 160, 40, 5, 160, 1'b0, "R10");
    run_wave();

    repeat (10) @(posedge clk);
    #3;
    summary();
    $finish;
  end
endmodule